// File: doc/BRIEF.md
# Audio Processor Control-Register Slave

This block is the serial control port of an audio processor. An external master talks to it over a two-wire I2C bus. The block watches SCL and SDA, accepts writes addressed to its fixed 7-bit address, and stores the data in nine 8-bit control registers. Those registers set the input source, loudness, volume, tone, the four speaker levels and muting. The analog path reads all nine registers in parallel from one flat output vector. The block pulls SDA low through an output-enable for acknowledges and read data. It never drives SDA high.

A write starts with the address byte, then a subaddress byte. The low four bits of the subaddress pick the target register. Bit 4 decides whether each following data byte moves on to the next register or rewrites the same one. A read returns a status byte built from two live mute flags. The flags are sampled again before every byte, so a master can poll them without sending the address again. Both bus lines are brought into the system clock through a flop synchronizer, and every bus event is found by edge detection. The system clock must run at least eight times faster than SCL.

Top module: `audio_ctl_i2c_regs`

## Requirements
- R1: After reset, all nine registers read 0xFE on `regs_o` and SDA is released (`sda_oe_o` = 0).
- R2: Address byte 0x88 (write) or 0x89 (read) is acknowledged. Any other address byte is not acknowledged, and the block ignores the bus until the next START, so data sent after a wrong address changes no register.
- R3: The subaddress byte is always acknowledged. Its bits 3..0 select the register index and bit 4 enables auto-increment. Bits 7..5 have no effect.
- R4: With auto-increment set, consecutive data bytes go to consecutive indices. After index 8 the index wraps to 0. Above 8 the index counts up and wraps from 15 to 0.
- R5: With auto-increment clear, every data byte of the transfer rewrites the register at the selected index.
- R6: A data byte sent to index 9..15 is acknowledged and leaves all nine registers unchanged.
- R7: A read byte, sent MSB first, carries the soft-mute input at bit 2 and the zero-crossing-mute input at bit 1. Bits 7..3 and bit 0 read 0.
- R8: After the master acknowledges a read byte, the status is sampled again and sent as the next byte. A master NACK ends the read, and SDA is then left released.
- R9: The block changes `sda_oe_o` only while the synchronized SCL is low, and a STOP always leaves SDA released.
- R10: A data byte changes at most one register, and only while the block is driving the acknowledge for that byte.

Register indices: 0 input select, 1 loudness, 2 volume, 3 bass/treble, 4 left-front, 5 left-rear, 6 right-front, 7 right-rear, 8 mute. Register i is `regs_o[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| soft_mute_i | input | 1 | Live soft-mute status, high active |
| zc_mute_i | input | 1 | Live zero-crossing-mute status, high active |
| regs_o | output | NUM_REGS*8 | All control registers, index 0 in the low byte |

## Verification
The bench targets the index walk at its edges:
- A burst that crosses index 8. A design that stored the index without wrapping would stop writing after the last register.
- A burst that starts in the unused range 9..15. A design that did not filter the index would corrupt a register.
- A burst with auto-increment clear. A design that still advanced the index would spread the bytes over several registers.

It also sends a foreign address followed by data; a design that failed to drop out would write registers. Reads are repeated with the mute inputs changed between bytes. A design that latched the status only once would return stale bits, and one that put the flags at the wrong positions would fail at once. Subaddresses with bits 7..5 set catch a design that decoded those bits.

// File: rtl/audctl_pkg.sv
package audctl_pkg;
   localparam int BYTE_W  = 8;
   localparam int IDX_W   = 4;
   localparam int BIT_CW  = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_SUB,
      PH_WDATA,
      PH_RDATA,
      PH_SKIP
   } phase_t;

   // Advance a register index: wrap after the last implemented register,
   // otherwise count up (4-bit arithmetic wraps 15 to 0).
   function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] cur,
                                                   input logic [IDX_W-1:0] last);
      if (cur == last) return '0;
      return cur + 1'b1;
   endfunction
endpackage

// File: rtl/audctl_line_sync.sv
module audctl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/audctl_bus_events.sv
module audctl_bus_events #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   localparam int LINES = 2;

   logic [LINES-1:0] raw_v;
   logic [LINES-1:0] syn_v;
   logic [LINES-1:0] prev_v;

   assign raw_v = {sda_raw, scl_raw};

   generate
      for (genvar l = 0; l < LINES; l++) begin : g_line
         audctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_v[l]),
            .q    (syn_v[l])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_v <= '1;
      else        prev_v <= syn_v;
   end

   assign scl_q     = syn_v[0];
   assign sda_q     = syn_v[1];
   assign scl_rise  = syn_v[0] & ~prev_v[0];
   assign scl_fall  = ~syn_v[0] & prev_v[0];
   assign start_evt = syn_v[0] & prev_v[0] & prev_v[1] & ~syn_v[1];
   assign stop_evt  = syn_v[0] & prev_v[0] & ~prev_v[1] & syn_v[1];
endmodule

// File: rtl/audctl_link_fsm.sv
module audctl_link_fsm
   import audctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1000100,
   parameter int         NUM_REGS = 9,
   parameter int         AINC_BIT = 4,
   parameter int         SM_BIT   = 2,
   parameter int         ZM_BIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_q,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              soft_mute_i,
   input  logic              zc_mute_i,
   output logic              drive_low,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data
);
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_REGS - 1);
   localparam logic [BIT_CW-1:0] FULL_CNT = BIT_CW'(BYTE_W);

   phase_t              ph;
   logic [BIT_CW-1:0]   bitcnt;
   logic                in_ack;
   logic                rd_dir;
   logic                ainc;
   logic                mack;
   logic [BYTE_W-1:0]   shreg;
   logic [BYTE_W-1:0]   tx;
   logic [IDX_W-1:0]    idx;
   logic [BYTE_W-1:0]   status;

   always_comb begin
      status         = '0;
      status[SM_BIT] = soft_mute_i;
      status[ZM_BIT] = zc_mute_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         bitcnt    <= '0;
         in_ack    <= 1'b0;
         rd_dir    <= 1'b0;
         ainc      <= 1'b0;
         mack      <= 1'b0;
         shreg     <= '0;
         tx        <= '0;
         idx       <= '0;
         drive_low <= 1'b0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_evt) begin
            ph        <= PH_IDLE;
            in_ack    <= 1'b0;
            drive_low <= 1'b0;
         end else if (start_evt) begin
            ph        <= PH_ADDR;
            bitcnt    <= '0;
            in_ack    <= 1'b0;
            drive_low <= 1'b0;
         end else begin
            case (ph)
               PH_ADDR, PH_SUB, PH_WDATA: begin
                  if (scl_rise && bitcnt < FULL_CNT) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_q};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL_CNT && !in_ack) begin
                     case (ph)
                        PH_ADDR: begin
                           if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                              drive_low <= 1'b1;
                              in_ack    <= 1'b1;
                              rd_dir    <= shreg[0];
                           end else begin
                              ph <= PH_SKIP;
                           end
                        end
                        PH_SUB: begin
                           drive_low <= 1'b1;
                           in_ack    <= 1'b1;
                           idx       <= shreg[IDX_W-1:0];
                           ainc      <= shreg[AINC_BIT];
                        end
                        default: begin
                           drive_low <= 1'b1;
                           in_ack    <= 1'b1;
                           wr_en     <= 1'b1;
                           wr_data   <= shreg;
                        end
                     endcase
                  end else if (scl_fall && in_ack) begin
                     in_ack    <= 1'b0;
                     bitcnt    <= '0;
                     drive_low <= 1'b0;
                     case (ph)
                        PH_ADDR: begin
                           if (rd_dir) begin
                              ph        <= PH_RDATA;
                              tx        <= status;
                              drive_low <= ~status[BYTE_W-1];
                           end else begin
                              ph <= PH_SUB;
                           end
                        end
                        PH_SUB:  ph <= PH_WDATA;
                        default: if (ainc) idx <= next_index(idx, LAST_IDX);
                     endcase
                  end
               end
               PH_RDATA: begin
                  if (scl_rise) begin
                     if (bitcnt < FULL_CNT) bitcnt <= bitcnt + 1'b1;
                     else if (in_ack)       mack   <= ~sda_q;
                  end else if (scl_fall) begin
                     if (in_ack) begin
                        in_ack <= 1'b0;
                        if (mack) begin
                           tx        <= status;
                           drive_low <= ~status[BYTE_W-1];
                           bitcnt    <= '0;
                        end else begin
                           ph        <= PH_SKIP;
                           drive_low <= 1'b0;
                        end
                     end else if (bitcnt == FULL_CNT) begin
                        drive_low <= 1'b0;
                        in_ack    <= 1'b1;
                     end else if (bitcnt != '0) begin
                        tx        <= {tx[BYTE_W-2:0], 1'b0};
                        drive_low <= ~tx[BYTE_W-2];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign wr_idx = idx;
endmodule

// File: rtl/audctl_reg_bank.sv
module audctl_reg_bank
   import audctl_pkg::*;
#(
   parameter int               NUM_REGS  = 9,
   parameter logic [BYTE_W-1:0] RESET_VAL = 8'hFE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [BYTE_W-1:0]          wr_data,
   output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic [BYTE_W-1:0] val;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                val <= RESET_VAL;
            else if (wr_en && wr_idx == IDX_W'(i))     val <= wr_data;
         end
         assign regs_o[i*BYTE_W +: BYTE_W] = val;
      end
   endgenerate
endmodule

// File: rtl/audio_ctl_i2c_regs.sv
module audio_ctl_i2c_regs
   import audctl_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR    = 7'b1000100,
   parameter int                NUM_REGS    = 9,
   parameter int                SYNC_STAGES = 2,
   parameter int                AINC_BIT    = 4,
   parameter int                SM_BIT      = 2,
   parameter int                ZM_BIT      = 1,
   parameter logic [BYTE_W-1:0] RESET_VAL   = 8'hFE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_oe_o,
   input  logic                       soft_mute_i,
   input  logic                       zc_mute_i,
   output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_regs
         $error("NUM_REGS must fit the 4-bit index field");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES below 2 leaves metastability unfiltered");
      end
      if (AINC_BIT < IDX_W || AINC_BIT >= BYTE_W) begin : g_bad_ainc
         $error("AINC_BIT must lie above the index field");
      end
      if (SM_BIT == ZM_BIT || SM_BIT >= BYTE_W || ZM_BIT >= BYTE_W) begin : g_bad_stat
         $error("status bit positions must be distinct and in range");
      end
   endgenerate

   logic              scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [BYTE_W-1:0] wr_data;

   audctl_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_raw  (scl_i),
      .sda_raw  (sda_i),
      .scl_q    (scl_q),
      .sda_q    (sda_q),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_evt(start_evt),
      .stop_evt (stop_evt)
   );

   audctl_link_fsm #(
      .DEV_ADDR(DEV_ADDR),
      .NUM_REGS(NUM_REGS),
      .AINC_BIT(AINC_BIT),
      .SM_BIT  (SM_BIT),
      .ZM_BIT  (ZM_BIT)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_q      (sda_q),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_evt  (start_evt),
      .stop_evt   (stop_evt),
      .soft_mute_i(soft_mute_i),
      .zc_mute_i  (zc_mute_i),
      .drive_low  (sda_oe_o),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data)
   );

   audctl_reg_bank #(
      .NUM_REGS (NUM_REGS),
      .RESET_VAL(RESET_VAL)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data),
      .regs_o (regs_o)
   );
endmodule

// File: rtl/audctl_checker.sv
module audctl_checker #(
   parameter int NUM_REGS = 9
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_q,
   input logic                  stop_evt,
   input logic                  sda_oe_o,
   input logic [NUM_REGS*8-1:0] regs_o
);
   logic [NUM_REGS*8-1:0] prev_regs;
   logic                  prev_valid;
   logic [NUM_REGS-1:0]   chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_regs  <= '0;
         prev_valid <= 1'b0;
      end else begin
         prev_regs  <= regs_o;
         prev_valid <= 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_chg
         assign chg[i] = prev_valid && (regs_o[i*8 +: 8] != prev_regs[i*8 +: 8]);
      end
   endgenerate

   AST_RESET_ALL_FE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> regs_o == {NUM_REGS{8'hFE}}); // R1

   AST_WRITE_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |-> sda_oe_o); // R10

   AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chg) <= 1); // R10

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe_o) && !$past(stop_evt)) |-> !scl_q); // R9

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe_o); // R9
endmodule

bind audio_ctl_i2c_regs audctl_checker #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_q   (scl_q),
   .stop_evt(stop_evt),
   .sda_oe_o(sda_oe_o),
   .regs_o  (regs_o)
);

// File: tb/sim_audio_ctl_i2c_regs.sv
`timescale 1ns/1ps
module sim_audio_ctl_i2c_regs;
   localparam int H = 12;
   localparam int NR = 9;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sm = 1'b0;
   logic zm = 1'b0;
   logic sda_oe;
   logic sda_line;
   logic [NR*8-1:0] regs;

   assign sda_line = sda_m & ~sda_oe;

   audio_ctl_i2c_regs u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .soft_mute_i(sm), .zc_mute_i(zm), .regs_o(regs)
   );

   int checks = 0;
   int fails = 0;
   logic [7:0] exp_r [NR];
   logic [7:0] wbuf [8];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; wt(H);
      sda_m = 1'b0; wt(H);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(H);
      scl_m = 1'b1; wt(H);
      sda_m = 1'b1; wt(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int k = 7; k >= 0; k--) begin
         sda_m = b[k]; wt(H);
         scl_m = 1'b1; wt(H);
         scl_m = 1'b0;
      end
      sda_m = 1'b1; wt(H);
      scl_m = 1'b1; wt(H/2);
      acked = !sda_line;
      wt(H/2);
      scl_m = 1'b0;
   endtask

   task automatic recv_byte(input bit give_ack, input logic nsm, input logic nzm, output logic [7:0] b);
      sda_m = 1'b1;
      b = '0;
      for (int k = 0; k < 8; k++) begin
         wt(H);
         scl_m = 1'b1; wt(H/2);
         b = {b[6:0], sda_line};
         wt(H/2);
         scl_m = 1'b0;
      end
      sda_m = ~give_ack; wt(H);
      scl_m = 1'b1;
      sm = nsm; zm = nzm;
      wt(H);
      scl_m = 1'b0;
      wt(1);
      sda_m = 1'b1;
   endtask

   function automatic logic [3:0] nxt(input logic [3:0] i);
      return (i == 4'd8) ? 4'd0 : i + 4'd1;
   endfunction

   function automatic logic [7:0] stat_byte(input logic s, input logic z);
      return {5'b0, s, z, 1'b0};
   endfunction

   task automatic check_regs(input string tag);
      for (int i = 0; i < NR; i++)
         chk(regs[i*8 +: 8] == exp_r[i], tag, regs[i*8 +: 8], exp_r[i]);
   endtask

   // full write transfer; updates the model
   task automatic wr_txn(input logic [7:0] sub, input int n, input string tag);
      bit a;
      logic [3:0] ix;
      bus_start();
      send_byte(8'h88, a); chk(a, "R2 write address ack", a, 1);
      send_byte(sub, a);   chk(a, "R3 subaddress ack", a, 1);
      ix = sub[3:0];
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], a);
         chk(a, "R6 data ack", a, 1);
         if (ix < 4'(NR)) exp_r[ix] = wbuf[k];
         if (sub[4]) ix = nxt(ix);
      end
      bus_stop();
      wt(4);
      chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
      check_regs(tag);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      bit a;
      logic [7:0] rb;
      logic ts, tz;
      void'($urandom(32'd5471));
      for (int i = 0; i < NR; i++) exp_r[i] = 8'hFE;
      wt(5);
      rst_n = 1'b1;
      wt(5);
      // R1 reset state
      check_regs("R1 reset value");
      chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);

      // R4 auto-increment across the wrap 7,8,0,1
      for (int k = 0; k < 4; k++) wbuf[k] = 8'h10 + 8'(k);
      wr_txn(8'h17, 4, "R4 wrap 8 to 0");

      // R5 no increment: index 2 rewritten, last byte stays
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      wr_txn(8'h02, 3, "R5 same register");

      // R6 indices above 8 discard, then wrap 15 -> 0
      wbuf[0] = 8'h55; wbuf[1] = 8'h66;
      wr_txn(8'h1F, 2, "R6 discard then wrap");
      wbuf[0] = 8'h99;
      wr_txn(8'h0C, 1, "R6 discard no increment");

      // R3 upper subaddress bits have no effect
      wbuf[0] = 8'h3C; wbuf[1] = 8'h4D;
      wr_txn(8'hF5, 2, "R3 bits 7..5 ignored");
      wbuf[0] = 8'h7E;
      wr_txn(8'hE6, 1, "R3 bits 7..5 ignored no inc");

      // R2 wrong address: no ack, following bytes ignored
      bus_start();
      send_byte(8'h8A, a); chk(!a, "R2 foreign address nack", a, 0);
      send_byte(8'h10, a); chk(!a, "R2 ignored sub nack", a, 0);
      send_byte(8'h00, a);
      bus_stop();
      wt(4);
      check_regs("R2 foreign address no write");
      bus_start();
      send_byte(8'h8B, a); chk(!a, "R2 foreign read nack", a, 0);
      bus_stop();

      // R7/R8 reads with status changing between bytes
      sm = 1'b1; zm = 1'b0;
      bus_start();
      send_byte(8'h89, a); chk(a, "R2 read address ack", a, 1);
      ts = 1'b1; tz = 1'b0;
      for (int k = 0; k < 6; k++) begin
         logic nsm, nzm;
         nsm = 1'($urandom); nzm = 1'($urandom);
         if (k == 1) begin nsm = 1'b1; nzm = 1'b1; end
         recv_byte(k != 5, nsm, nzm, rb);
         chk(rb == stat_byte(ts, tz), k == 0 ? "R7 status layout" : "R8 resampled status",
             rb, stat_byte(ts, tz));
         ts = nsm; tz = nzm;
      end
      wt(4);
      chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
      bus_stop();

      // random bursts mixed with reads
      for (int t = 0; t < 20; t++) begin
         logic [7:0] sub;
         int n;
         sub = 8'($urandom);
         n = 1 + int'($urandom % 6);
         for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
         wr_txn(sub, n, sub[4] ? "R4 random burst" : "R5 random burst");
         if (t % 5 == 0) begin
            sm = 1'($urandom); zm = 1'($urandom);
            ts = sm; tz = zm;
            bus_start();
            send_byte(8'h89, a); chk(a, "R2 read address ack", a, 1);
            recv_byte(1'b0, sm, zm, rb);
            chk(rb == stat_byte(ts, tz), "R7 random status", rb, stat_byte(ts, tz));
            bus_stop();
         end
      end
      check_regs("R10 final register image");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule